// File: doc/BRIEF.md
# Three-Stage x128 Interpolation Chain

This block raises a baseband sample stream by a factor of 128. It has three stages in a fixed order. The first is a pulse-shaping FIR that interpolates by 2. The second is an FIR that interpolates by 2 and pre-corrects the passband droop of the stage after it. The third is a five-section CIC that interpolates by 32.

Each FIR stage is built as two polyphase branches. One branch takes the even-indexed coefficients and the other takes the odd-indexed ones. Both branch sums are produced on the same edge. The first is released at once and the second is held back until the next output slot. The CIC keeps full precision internally, so its output is 20 bits wider than its 16-bit input.

The input is a signed Q15 sample, presented with a one-cycle strobe exactly once every 128 clocks. Once the chain has filled, it delivers one output sample on every clock. Each intermediate stage has its own valid flag and data port.

Top module: `interp128_chain`

## Requirements
- R1: Each accepted input strobe produces exactly 2 first-stage samples, 4 second-stage samples and 128 output samples. Once `dout_vld` rises, it stays high on every clock until reset.
- R2: `s1_dat` is bit-exact with a zero-stuffed-by-2 direct convolution of the input with a 63-tap symmetric response. Each coefficient is round(c*32768), with centre 11069 and neighbours 9096 and 4420. The even phase comes first.
- R3: The first `s1_vld` pulse for an input comes in the clock after the input strobe edge. The second comes 64 clocks after the first. Each pulse lasts one clock.
- R4: `s2_dat` is bit-exact with a zero-stuffed-by-2 convolution of the `s1_dat` sequence with a 21-tap symmetric response. Its centre is 12127, flanked by 9486 and 3758, with side lobes of -1940. The even phase comes first.
- R5: Each `s1_vld` pulse is followed by an `s2_vld` pulse in the next clock, and by a second one 32 clocks after that.
- R6: Each FIR accumulator (Q30) is reduced to Q15 by adding 2^14 and then arithmetically shifting right by 15. The result is clamped to the signed 16-bit range.
- R7: `dout` is the 36-bit exact result of the second-stage stream, zero-stuffed by 32 and passed through five cascaded 32-sample moving sums.
- R8: After the first input strobe edge, `dout_vld` is low 6 clocks later and high 7 clocks later.
- R9: A synchronous reset clears all delay lines, combs, integrators and valid flags. While `dout_vld` is low, `dout` reads zero, and a stream started after reset matches a model that starts from zero state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din_vld | input | 1 | Input strobe, at most once per 128 clocks |
| din | input | 16 | Signed Q15 input sample |
| s1_vld | output | 1 | First-stage sample valid |
| s1_dat | output | 16 | First-stage sample, signed Q15 |
| s2_vld | output | 1 | Second-stage sample valid |
| s2_dat | output | 16 | Second-stage sample, signed Q15 |
| dout_vld | output | 1 | Output valid, continuous once filled |
| dout | output | 36 | Full-precision CIC output |

## Verification
The assertions check the timing rules on every cycle:
- a first-stage pulse lands only in the two slots after a strobe and never lasts two clocks;
- each first-stage pulse is followed at once by a second-stage pulse;
- the output valid never falls once it has risen;
- the output stays at zero while it is invalid.

The numeric behaviour can only be shown by the bench's scenarios, which compare every stage against a direct-convolution model:
- the coefficient values;
- the half-up rounding between stages;
- the moving-sum equivalence of the CIC.

The bench drives an impulse, a swept tone and a full-scale negative step. The exact fill latency and the clearing of state by a mid-stream reset are also checked only by the bench.

// File: rtl/interp128_chain.sv
module interp128_chain #(
  parameter int DW   = 16,
  parameter int FW   = 15,
  parameter int AW   = 40,
  parameter int NSEC = 5,
  parameter int RCIC = 32,
  parameter int OW   = DW + (NSEC - 1) * $clog2(RCIC)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 din_vld,
  input  logic signed [DW-1:0] din,
  output logic                 s1_vld,
  output logic signed [DW-1:0] s1_dat,
  output logic                 s2_vld,
  output logic signed [DW-1:0] s2_dat,
  output logic                 dout_vld,
  output logic signed [OW-1:0] dout
);
  localparam int N1  = 63;
  localparam int N2  = 21;
  localparam int L1  = (N1 + 1) / 2;
  localparam int L2  = (N2 + 1) / 2;
  localparam int T1  = 2 * RCIC;
  localparam int T2  = RCIC;
  localparam int TW  = $clog2(T1) + 1;
  localparam int PW  = 2 * DW;
  localparam logic signed [AW-1:0] HALF = AW'(1) <<< (FW - 1);
  localparam logic signed [AW-1:0] MAXV = (AW'(1) <<< (DW - 1)) - AW'(1);
  localparam logic signed [AW-1:0] MINV = -(AW'(1) <<< (DW - 1));

  function automatic logic signed [DW-1:0] coef_a(input int k);
    int m;
    m = (k > N1 / 2) ? (N1 - 1 - k) : k;
    case (m)
      0: return 16'sd23;     1: return 16'sd69;     2: return -16'sd7;     3: return -16'sd82;
      4: return -16'sd88;    5: return 16'sd43;     6: return 16'sd161;    7: return 16'sd105;
      8: return -16'sd111;   9: return -16'sd242;   10: return -16'sd102;  11: return 16'sd197;
      12: return 16'sd324;   13: return 16'sd95;    14: return -16'sd292;  15: return -16'sd423;
      16: return -16'sd105;  17: return 16'sd406;   18: return 16'sd580;   19: return 16'sd131;
      20: return -16'sd596;  21: return -16'sd836;  22: return -16'sd154;  23: return 16'sd940;
      24: return 16'sd1278;  25: return 16'sd161;   26: return -16'sd1668; 27: return -16'sd2290;
      28: return -16'sd151;  29: return 16'sd4420;  30: return 16'sd9096;  31: return 16'sd11069;
      default: return 16'sd0;
    endcase
  endfunction

  function automatic logic signed [DW-1:0] coef_b(input int k);
    int m;
    m = (k > N2 / 2) ? (N2 - 1 - k) : k;
    case (m)
      0: return -16'sd23;   1: return -16'sd29;   2: return 16'sd128;   3: return 16'sd393;
      4: return 16'sd206;   5: return -16'sd875;  6: return -16'sd1940; 7: return -16'sd777;
      8: return 16'sd3758;  9: return 16'sd9486;  10: return 16'sd12127;
      default: return 16'sd0;
    endcase
  endfunction

  function automatic logic signed [DW-1:0] rnd(input logic signed [AW-1:0] a);
    logic signed [AW-1:0] t;
    t = (a + HALF) >>> FW;
    if (t > MAXV) t = MAXV;
    else if (t < MINV) t = MINV;
    return t[DW-1:0];
  endfunction

  logic signed [DW-1:0] d1 [L1-1];
  logic signed [DW-1:0] d2 [L2-1];
  logic signed [DW-1:0] h1, h2;
  logic [TW-1:0]        t1, t2;
  logic signed [AW-1:0] a1e, a1o, a2e, a2o;

  always_comb begin
    logic signed [DW-1:0] tap;
    logic signed [PW-1:0] p;
    a1e = '0;
    a1o = '0;
    for (int j = 0; j < L1; j++) begin
      tap = (j == 0) ? din : d1[(j == 0) ? 0 : j - 1];
      p   = coef_a(2 * j) * tap;
      a1e = a1e + {{(AW-PW){p[PW-1]}}, p};
      if (2 * j + 1 < N1) begin
        p   = coef_a(2 * j + 1) * tap;
        a1o = a1o + {{(AW-PW){p[PW-1]}}, p};
      end
    end
  end

  always_comb begin
    logic signed [DW-1:0] tap;
    logic signed [PW-1:0] p;
    a2e = '0;
    a2o = '0;
    for (int j = 0; j < L2; j++) begin
      tap = (j == 0) ? s1_dat : d2[(j == 0) ? 0 : j - 1];
      p   = coef_b(2 * j) * tap;
      a2e = a2e + {{(AW-PW){p[PW-1]}}, p};
      if (2 * j + 1 < N2) begin
        p   = coef_b(2 * j + 1) * tap;
        a2o = a2o + {{(AW-PW){p[PW-1]}}, p};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < L1 - 1; j++) d1[j] <= '0;
      s1_dat <= '0;
      h1     <= '0;
      t1     <= '0;
      s1_vld <= 1'b0;
    end else begin
      s1_vld <= 1'b0;
      if (din_vld) begin
        d1[0] <= din;
        for (int j = 1; j < L1 - 1; j++) d1[j] <= d1[j-1];
        s1_dat <= rnd(a1e);
        h1     <= rnd(a1o);
        t1     <= TW'(T1);
        s1_vld <= 1'b1;
      end else if (t1 != '0) begin
        t1 <= t1 - 1'b1;
        if (t1 == TW'(1)) begin
          s1_dat <= h1;
          s1_vld <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < L2 - 1; j++) d2[j] <= '0;
      s2_dat <= '0;
      h2     <= '0;
      t2     <= '0;
      s2_vld <= 1'b0;
    end else begin
      s2_vld <= 1'b0;
      if (s1_vld) begin
        d2[0] <= s1_dat;
        for (int j = 1; j < L2 - 1; j++) d2[j] <= d2[j-1];
        s2_dat <= rnd(a2e);
        h2     <= rnd(a2o);
        t2     <= TW'(T2);
        s2_vld <= 1'b1;
      end else if (t2 != '0) begin
        t2 <= t2 - 1'b1;
        if (t2 == TW'(1)) begin
          s2_dat <= h2;
          s2_vld <= 1'b1;
        end
      end
    end
  end

  logic signed [OW-1:0] cv [NSEC+1];
  logic signed [OW-1:0] cd [NSEC];
  logic signed [OW-1:0] ig [NSEC];
  logic signed [OW-1:0] creg;
  logic                 stf, run;
  logic [NSEC-1:0]      vsr;

  always_comb begin
    cv[0] = {{(OW-DW){s2_dat[DW-1]}}, s2_dat};
    for (int i = 0; i < NSEC; i++) cv[i+1] = cv[i] - cd[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSEC; i++) cd[i] <= '0;
      creg <= '0;
      stf  <= 1'b0;
      run  <= 1'b0;
      vsr  <= '0;
    end else begin
      if (s2_vld) begin
        for (int i = 0; i < NSEC; i++) cd[i] <= cv[i];
        creg <= cv[NSEC];
      end
      stf <= s2_vld;
      run <= run | s2_vld;
      vsr <= {vsr[NSEC-2:0], run};
    end
  end

  generate
    for (genvar k = 0; k < NSEC; k++) begin : g_int
      always_ff @(posedge clk) begin
        if (rst) ig[k] <= '0;
        else if (k == 0) ig[k] <= ig[k] + (stf ? creg : '0);
        else ig[k] <= ig[k] + ig[(k == 0) ? 0 : k - 1];
      end
    end
  endgenerate

  assign dout     = ig[NSEC-1];
  assign dout_vld = vsr[NSEC-1];
endmodule

module interp128_chain_chk #(
  parameter int OW   = 36,
  parameter int SLOT = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          din_vld,
  input logic          s1_vld,
  input logic          s2_vld,
  input logic          dout_vld,
  input logic [OW-1:0] dout
);
  logic [7:0] gap;
  always_ff @(posedge clk) begin
    if (rst) gap <= 8'hff;
    else if (din_vld) gap <= '0;
    else if (gap != 8'hff) gap <= gap + 1'b1;
  end

  p_s1_single_r3: assert property (@(posedge clk) disable iff (rst) s1_vld |=> !s1_vld);
  p_s1_slot_r3:   assert property (@(posedge clk) disable iff (rst)
                    s1_vld |-> (gap == 8'd0 || gap == 8'(SLOT)));
  p_s2_follow_r5: assert property (@(posedge clk) disable iff (rst) s1_vld |=> s2_vld);
  p_vld_hold_r1:  assert property (@(posedge clk) disable iff (rst) dout_vld |=> dout_vld);
  p_quiet_r9:     assert property (@(posedge clk) disable iff (rst) !dout_vld |-> dout == '0);
endmodule

bind interp128_chain interp128_chain_chk #(.OW(OW), .SLOT(2 * RCIC)) u_chk (
  .clk(clk), .rst(rst), .din_vld(din_vld), .s1_vld(s1_vld),
  .s2_vld(s2_vld), .dout_vld(dout_vld), .dout(dout)
);

// File: tb/test_interp128_chain.sv
`timescale 1ns/1ps
module test_interp128_chain;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din_vld = 1'b0;
  logic signed [15:0] din = '0;
  logic s1_vld, s2_vld, dout_vld;
  logic signed [15:0] s1_dat, s2_dat;
  logic signed [35:0] dout;

  always #10 clk = ~clk;

  interp128_chain i_interp128_chain (
    .clk(clk), .rst(rst), .din_vld(din_vld), .din(din),
    .s1_vld(s1_vld), .s1_dat(s1_dat), .s2_vld(s2_vld), .s2_dat(s2_dat),
    .dout_vld(dout_vld), .dout(dout)
  );

  int n_run = 0, n_fail = 0;
  longint q1[$], q2[$], q3[$];
  longint xh[32], sh[11];
  longint bh[5][32];
  logic prev_vld = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic longint ca(input int k);
    int m;
    m = (k > 31) ? 62 - k : k;
    case (m)
      0: return 23;     1: return 69;     2: return -7;     3: return -82;
      4: return -88;    5: return 43;     6: return 161;    7: return 105;
      8: return -111;   9: return -242;   10: return -102;  11: return 197;
      12: return 324;   13: return 95;    14: return -292;  15: return -423;
      16: return -105;  17: return 406;   18: return 580;   19: return 131;
      20: return -596;  21: return -836;  22: return -154;  23: return 940;
      24: return 1278;  25: return 161;   26: return -1668; 27: return -2290;
      28: return -151;  29: return 4420;  30: return 9096;  31: return 11069;
      default: return 0;
    endcase
  endfunction

  function automatic longint cb(input int k);
    int m;
    m = (k > 10) ? 20 - k : k;
    case (m)
      0: return -23;   1: return -29;   2: return 128;   3: return 393;
      4: return 206;   5: return -875;  6: return -1940; 7: return -777;
      8: return 3758;  9: return 9486;  10: return 12127;
      default: return 0;
    endcase
  endfunction

  function automatic longint rs(input longint a);
    longint t;
    t = (a + 64'sd16384) >>> 15;
    if (t > 32767) t = 32767;
    if (t < -32768) t = -32768;
    return t;
  endfunction

  task automatic model_clear();
    for (int j = 0; j < 32; j++) xh[j] = 0;
    for (int j = 0; j < 11; j++) sh[j] = 0;
    for (int s = 0; s < 5; s++) for (int j = 0; j < 32; j++) bh[s][j] = 0;
    q1.delete(); q2.delete(); q3.delete();
  endtask

  task automatic model_cic(input longint v);
    for (int n = 0; n < 32; n++) begin
      longint u;
      u = (n == 0) ? v : 0;
      for (int s = 0; s < 5; s++) begin
        longint acc;
        for (int j = 31; j > 0; j--) bh[s][j] = bh[s][j-1];
        bh[s][0] = u;
        acc = 0;
        for (int j = 0; j < 32; j++) acc += bh[s][j];
        u = acc;
      end
      q3.push_back(u);
    end
  endtask

  task automatic model_s2(input longint v);
    for (int j = 10; j > 0; j--) sh[j] = sh[j-1];
    sh[0] = v;
    for (int p = 0; p < 2; p++) begin
      longint a, r;
      a = 0;
      for (int j = 0; j < 11; j++) a += cb(2 * j + p) * sh[j];
      r = rs(a);
      q2.push_back(r);
      model_cic(r);
    end
  endtask

  task automatic model_push(input longint v);
    for (int j = 31; j > 0; j--) xh[j] = xh[j-1];
    xh[0] = v;
    for (int p = 0; p < 2; p++) begin
      longint a, r;
      a = 0;
      for (int j = 0; j < 32; j++) a += ca(2 * j + p) * xh[j];
      r = rs(a);
      q1.push_back(r);
      model_s2(r);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (s1_vld) begin
        if (q1.size() > 0) begin
          longint e; e = q1.pop_front();
          chk(longint'(s1_dat) == e, "R2/R6 stage-1 sample", longint'(s1_dat), e);
        end else chk(1'b0, "R1 unexpected stage-1 sample", longint'(s1_dat), 0);
      end
      if (s2_vld) begin
        if (q2.size() > 0) begin
          longint e; e = q2.pop_front();
          chk(longint'(s2_dat) == e, "R4/R6 stage-2 sample", longint'(s2_dat), e);
        end else chk(1'b0, "R1 unexpected stage-2 sample", longint'(s2_dat), 0);
      end
      if (dout_vld && q3.size() > 0) begin
        longint e; e = q3.pop_front();
        chk(longint'(dout) == e, "R7 output sample", longint'(dout), e);
      end
      if (prev_vld && !dout_vld) chk(1'b0, "R1 output valid dropped", 0, 1);
      prev_vld <= dout_vld;
    end else prev_vld <= 1'b0;
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    din_vld = 1'b0;
    model_clear();
    repeat (3) @(negedge clk);
    chk(!dout_vld && !s1_vld && !s2_vld, "R9 valids cleared in reset", longint'(dout_vld), 0);
    chk(dout == '0, "R9 output zero in reset", longint'(dout), 0);
    rst = 1'b0;
  endtask

  task automatic send(input int v, input bit timing);
    @(negedge clk);
    din = 16'(v);
    din_vld = 1'b1;
    model_push(longint'(v));
    @(negedge clk);
    din_vld = 1'b0;
    if (timing) chk(s1_vld, "R3 first stage-1 slot", longint'(s1_vld), 1);
    for (int i = 1; i < 127; i++) begin
      @(negedge clk);
      if (timing) begin
        if (i == 64) chk(s1_vld, "R3 second stage-1 slot", longint'(s1_vld), 1);
        if (i == 1 || i == 33 || i == 65 || i == 97)
          chk(s2_vld, "R5 stage-2 slot", longint'(s2_vld), 1);
        if (i == 6) chk(!dout_vld, "R8 output not yet valid", longint'(dout_vld), 0);
        if (i == 7) chk(dout_vld, "R8 output valid at fill", longint'(dout_vld), 1);
      end
    end
  endtask

  task automatic finish_scn(input string name);
    repeat (16) @(negedge clk);
    chk(q1.size() == 0 && q2.size() == 0, {"R1 all stage samples seen: ", name},
        longint'(q1.size() + q2.size()), 0);
  endtask

  initial begin
    model_clear();
    do_reset();
    send(32767, 1'b1);
    for (int k = 0; k < 40; k++) send(0, 1'b0);
    finish_scn("impulse");

    do_reset();
    for (int k = 0; k < 80; k++) begin
      real ph;
      ph = 0.002 * real'(k * k) + 0.05 * real'(k);
      send($rtoi(30000.0 * $sin(ph)), k == 0);
    end
    finish_scn("sweep");

    do_reset();
    for (int k = 0; k < 30; k++) send(-32768, k == 0);
    finish_scn("step");
    chk(dout_vld && dout < 0, "R7 full-scale step output negative", longint'(dout), -1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule